// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block watches for software that has stopped running as intended. A clock divider feeds a down counter. If software does not restart the count often enough, the counter passes zero and the block asks for either an interrupt or a reset of the system. After reset the block stays idle. A start strobe arms it, and from then on a refresh strobe puts the count back to its full value.

Software chooses between a short and a long divider ratio. It can also move the underflow action from interrupt to reset, but not back: only a system reset clears that choice. Two inputs report low-power states. While either is high, the divider and the counter hold their values, and counting picks up from those values when both go low. The defaults give a 15-bit counter with divide-by-16 or divide-by-128. One timeout then lasts the divide value times 32768 clock cycles.

Top module: `wdt_top`

## Requirements
- R1: After rst_ni goes low, irq_o and rst_req_o are 0. They stay 0, and no counting takes place, until start_wr_i is sampled high. A refresh_wr_i strobe while idle does not start the block.
- R2: On a cfg_wr_i strobe, the block stores cfg_div_sel_i. A value of 0 selects a divide ratio of 2^DIV_LO_LOG2 and a value of 1 selects 2^DIV_HI_LOG2.
- R3: On underflow, the block raises irq_o if the stored action mode is 0 (interrupt). It raises rst_req_o if the mode is 1 (reset).
- R4: The first underflow output appears exactly ratio × 2^CNT_W cycles after the clock edge that samples start_wr_i.
- R5: A start strobe, or a refresh strobe while running, loads the counter to all ones (2^CNT_W-1) and clears the divider. The next timeout then falls one full period after that edge.
- R6: A cfg_wr_i with cfg_rst_mode_i=1 sets the action mode to 1. A later cfg_wr_i with cfg_rst_mode_i=0 leaves the mode at 1. Only rst_ni returns it to 0.
- R7: While stop_i or wait_i is high, the divider and the counter hold their values. Each halted cycle delays the timeout by exactly one cycle.
- R8: In interrupt mode, irq_o is high for a single cycle. The counter then reloads to all ones and keeps running, so irq_o repeats every period.
- R9: A refresh strobe in the same cycle as an underflow wins over the underflow. No irq_o or rst_req_o results, and the next period starts at that edge.
- R10: A change of the divider select while running takes effect at the next divider wrap, not at once.
- R11: Once rst_req_o is set, it stays high until rst_ni.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_wr_i | input | 1 | Start strobe: arms the block and loads the counter |
| refresh_wr_i | input | 1 | Refresh strobe: reloads the counter while running |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_div_sel_i | input | 1 | Divider select written by cfg_wr_i (0 short, 1 long) |
| cfg_rst_mode_i | input | 1 | Action mode written by cfg_wr_i (1 sets reset mode) |
| stop_i | input | 1 | Stop-mode halt, freezes counting |
| wait_i | input | 1 | Wait-mode halt, freezes counting |
| irq_o | output | 1 | Single-cycle interrupt request on underflow |
| rst_req_o | output | 1 | Held reset request on underflow in reset mode |

## Verification
A wrong divider phase, a wrong divider ratio or a wrong counter value has only one visible effect: the timeout arrives on the wrong cycle. The bench therefore measures the exact cycle distance from start, refresh, halt or select change to the first output edge. The error shows up no later than one full timeout period. A wrong action mode shows up at the first underflow, as a signal on the wrong output pin. A lost priority shows up as a pulse in the very cycle where a refresh should have masked it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    ACT_IRQ = 1'b0,
    ACT_RST = 1'b1
  } wdt_act_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV_LO_LOG2 = 4,
  parameter int unsigned DIV_HI_LOG2 = 7
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   run_i,
  input  logic                   sel_i,
  output logic                   tick_o,
  output logic [DIV_HI_LOG2-1:0] pre_o
);
  localparam int unsigned PW = DIV_HI_LOG2;
  localparam logic [PW-1:0] LAST_LO = PW'((1 << DIV_LO_LOG2) - 1);
  localparam logic [PW-1:0] LAST_HI = PW'((1 << DIV_HI_LOG2) - 1);

  logic [PW-1:0] pre_q;
  logic          sel_act_q;
  logic [PW-1:0] last;

  assign last   = sel_act_q ? LAST_HI : LAST_LO;
  assign tick_o = run_i && (pre_q == last);
  assign pre_o  = pre_q;

  // select is latched only when the divider wraps or is cleared
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q     <= '0;
      sel_act_q <= 1'b0;
    end else if (clear_i) begin
      pre_q     <= '0;
      sel_act_q <= sel_i;
    end else if (run_i) begin
      if (tick_o) begin
        pre_q     <= '0;
        sel_act_q <= sel_i;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign uf_o  = tick_i && (cnt_q == '0) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= FULL;
    end else if (load_i) begin
      cnt_q <= FULL;
    end else if (tick_i) begin
      cnt_q <= (cnt_q == '0) ? FULL : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     mode_set_i,
  input  logic     uf_i,
  output wdt_act_e mode_o,
  output logic     irq_o,
  output logic     rst_req_o
);
  wdt_act_e mode_q;
  logic     irq_q;
  logic     rst_q;

  assign mode_o    = mode_q;
  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= ACT_IRQ;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (mode_set_i) mode_q <= ACT_RST;  // one-way
      irq_q <= uf_i && (mode_q == ACT_IRQ);
      if (uf_i && (mode_q == ACT_RST)) rst_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 15,
  parameter int unsigned DIV_LO_LOG2 = 4,
  parameter int unsigned DIV_HI_LOG2 = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_wr_i,
  input  logic refresh_wr_i,
  input  logic cfg_wr_i,
  input  logic cfg_div_sel_i,
  input  logic cfg_rst_mode_i,
  input  logic stop_i,
  input  logic wait_i,
  output logic irq_o,
  output logic rst_req_o
);
  logic                   running_q;
  logic                   div_sel_q;
  logic                   load;
  logic                   run;
  logic                   tick;
  logic                   uf;
  logic [CNT_W-1:0]       cnt;
  logic [DIV_HI_LOG2-1:0] pre_cnt;
  wdt_act_e               mode;

  assign load = start_wr_i || (refresh_wr_i && running_q);
  assign run  = running_q && !stop_i && !wait_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      div_sel_q <= 1'b0;
    end else begin
      if (start_wr_i) running_q <= 1'b1;
      if (cfg_wr_i)   div_sel_q <= cfg_div_sel_i;
    end
  end

  wdt_prescaler #(
    .DIV_LO_LOG2(DIV_LO_LOG2),
    .DIV_HI_LOG2(DIV_HI_LOG2)
  ) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(load),
    .run_i  (run),
    .sel_i  (div_sel_q),
    .tick_o (tick),
    .pre_o  (pre_cnt)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .tick_i(tick),
    .cnt_o (cnt),
    .uf_o  (uf)
  );

  wdt_action u_act (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_set_i(cfg_wr_i && cfg_rst_mode_i),
    .uf_i      (uf),
    .mode_o    (mode),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CNT_W = 15,
  parameter int unsigned PW    = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_wr_i,
  input logic             refresh_wr_i,
  input logic             stop_i,
  input logic             wait_i,
  input logic             running,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [PW-1:0]    pre,
  input logic             irq_o,
  input logic             rst_req_o
);
  localparam logic [CNT_W-1:0] FULL = '1;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running |-> (!irq_o && !rst_req_o));

  a_r8_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r11_rst_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> rst_req_o);

  a_r3_no_irq_in_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !irq_o);

  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_wr_i || (refresh_wr_i && running)) |=> (cnt == FULL && pre == '0));

  a_r7_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running && (stop_i || wait_i) && !start_wr_i && !refresh_wr_i)
    |=> ($stable(cnt) && $stable(pre)));

  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && cnt != '0 && !start_wr_i && !refresh_wr_i)
    |=> (cnt == $past(cnt) - 1'b1));

  a_r9_refresh_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refresh_wr_i && running && !rst_req_o) |=> (!irq_o && !rst_req_o));
endmodule

bind wdt_top wdt_checker #(.CNT_W(CNT_W), .PW(DIV_HI_LOG2)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_wr_i  (start_wr_i),
  .refresh_wr_i(refresh_wr_i),
  .stop_i      (stop_i),
  .wait_i      (wait_i),
  .running     (running_q),
  .tick        (tick),
  .cnt         (cnt),
  .pre         (pre_cnt),
  .irq_o       (irq_o),
  .rst_req_o   (rst_req_o)
);

// File: tb/wdt_top_tb_top.sv
module wdt_top_tb_top;
  localparam int CW   = 4;
  localparam int LO   = 1;
  localparam int HI   = 3;
  localparam int P_LO = (1 << LO) * (1 << CW);
  localparam int P_HI = (1 << HI) * (1 << CW);
  localparam int LIMIT = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_wr = 1'b0, refresh_wr = 1'b0, cfg_wr = 1'b0;
  logic cfg_sel = 1'b0, cfg_mode = 1'b0, stop = 1'b0, wt = 1'b0;
  logic irq, rst_req;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  wdt_top #(.CNT_W(CW), .DIV_LO_LOG2(LO), .DIV_HI_LOG2(HI)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_wr_i(start_wr), .refresh_wr_i(refresh_wr),
    .cfg_wr_i(cfg_wr), .cfg_div_sel_i(cfg_sel), .cfg_rst_mode_i(cfg_mode),
    .stop_i(stop), .wait_i(wt), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start_wr = 0; refresh_wr = 0; cfg_wr = 0; stop = 0; wt = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input bit sel, input bit mode);
    cfg_sel = sel; cfg_mode = mode; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // returns at the negedge after the sampling edge (index 0)
  task automatic strobe_start();
    start_wr = 1'b1;
    @(negedge clk);
    start_wr = 1'b0;
  endtask

  task automatic count_to_event(inout int n);
    while (!irq && !rst_req && n < LIMIT) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset_idle();
    do_reset();
    check(irq == 0 && rst_req == 0, "R1 reset outputs", {irq, rst_req}, 0);
    refresh_wr = 1'b1; @(negedge clk); refresh_wr = 1'b0;
    begin
      int n = 0;
      count_to_event(n);
      check(n == LIMIT, "R1 idle no timeout", n, LIMIT);
    end
  endtask

  task automatic t_short_period();
    int n = 0;
    do_reset();
    strobe_start();
    count_to_event(n);
    check(n == P_LO, "R4 R2 short period", n, P_LO);
    check(irq == 1 && rst_req == 0, "R3 irq action", {irq, rst_req}, 2);
    @(negedge clk);
    check(irq == 0, "R8 irq one cycle", irq, 0);
    n = 1;
    count_to_event(n);
    check(n == P_LO, "R8 repeat period", n, P_LO);
  endtask

  task automatic t_long_period();
    int n = 0;
    do_reset();
    cfg_write(1'b1, 1'b0);
    strobe_start();
    count_to_event(n);
    check(n == P_HI, "R2 R4 long period", n, P_HI);
  endtask

  task automatic t_refresh();
    int n = 0;
    do_reset();
    strobe_start();
    repeat (19) @(negedge clk);
    refresh_wr = 1'b1; @(negedge clk); refresh_wr = 1'b0;
    count_to_event(n);
    check(n == P_LO, "R5 refresh reload", n, P_LO);
  endtask

  task automatic t_halt();
    int n = 0;
    do_reset();
    strobe_start();
    repeat (10) @(negedge clk);
    n = 10;
    stop = 1'b1;
    repeat (30) begin @(negedge clk); n++; end
    stop = 1'b0; wt = 1'b1;
    repeat (20) begin @(negedge clk); n++; end
    wt = 1'b0;
    check(irq == 0, "R7 no timeout while halted", irq, 0);
    count_to_event(n);
    check(n == P_LO + 50, "R7 halt delay", n, P_LO + 50);
  endtask

  task automatic t_sel_change();
    int n = 0;
    do_reset();
    strobe_start();
    repeat (2) begin @(negedge clk); n++; end
    cfg_write(1'b1, 1'b0);
    n++;
    count_to_event(n);
    check(n == 116, "R10 select at next wrap", n, 116);
  endtask

  task automatic t_refresh_vs_underflow();
    int n = 0;
    do_reset();
    strobe_start();
    repeat (P_LO - 1) begin @(negedge clk); n++; end
    refresh_wr = 1'b1; @(negedge clk); refresh_wr = 1'b0; n++;
    check(irq == 0 && rst_req == 0, "R9 refresh beats underflow", {irq, rst_req}, 0);
    count_to_event(n);
    check(n == 2 * P_LO, "R9 next period", n, 2 * P_LO);
  endtask

  task automatic t_sticky_mode();
    int n = 0;
    bit dropped = 0, irq_seen = 0;
    do_reset();
    cfg_write(1'b0, 1'b1);
    cfg_write(1'b0, 1'b0);
    strobe_start();
    count_to_event(n);
    check(n == P_LO && rst_req == 1 && irq == 0, "R6 R3 reset action", n, P_LO);
    repeat (100) begin
      @(negedge clk);
      if (!rst_req) dropped = 1;
      if (irq) irq_seen = 1;
    end
    check(!dropped, "R11 reset request held", dropped, 0);
    check(!irq_seen, "R3 no irq in reset mode", irq_seen, 0);
    do_reset();
    check(rst_req == 0, "R11 cleared by rst_ni", rst_req, 0);
    n = 0;
    strobe_start();
    count_to_event(n);
    check(irq == 1 && rst_req == 0, "R6 mode back to irq", {irq, rst_req}, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_short_period();
    t_long_period();
    t_refresh();
    t_halt();
    t_sel_change();
    t_refresh_vs_underflow();
    t_sticky_mode();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule